// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block produces the instruction address of a small 8-bit controller core. It holds a 13-bit program counter (PC). Each cycle a one-hot-free operation code says how the PC moves on: it can step by one, take a new low byte from software, add an offset to the low byte, branch to an 11-bit literal, call, return, or take the interrupt vector. Address bits above the low byte come from a separate 5-bit holding register. The kind of load decides which of its bits are used.

Return addresses live in an 8-entry circular stack. Software can neither read nor write its pointer. A call or an interrupt pushes, and any of the three return codes pops. When more than eight pushes happen the oldest entry is overwritten with no warning, and popping past empty wraps the same way. A small state machine has two states. BOOT is the single cycle after reset is released; the PC stays at zero and the operation code is ignored. RUN is normal sequencing. Transitions: reset → BOOT, BOOT → RUN unconditionally, RUN → RUN.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and in the BOOT cycle that follows its release, `pc_o` is 0x0000 and `hi_rd_o` is 0x00. The operation code given in the BOOT cycle has no effect. Reset also returns the stack pointer to entry 0.
- R2: Code 0 (step) sets PC to PC+1 modulo 8192, so 0x1FFF is followed by 0x0000.
- R3: Code 1 (set low) loads PC[7:0] from `wdata_i` and PC[12:8] from holding bits [4:0]. The holding value used is the one stored before this cycle, even when the holding register is written in the same cycle.
- R4: Code 2 (add low) sets PC[7:0] to (PC[7:0] + `wdata_i`) mod 256 with no carry upward, and sets PC[12:8] from holding bits [4:0].
- R5: Code 3 (branch) sets PC[10:0] to `lit_i` and PC[12:11] to holding bits [4:3].
- R6: Code 4 (call) pushes PC+1 and then branches exactly as in R5. A later return brings back that address.
- R7: Code 8 (interrupt) pushes the current PC unchanged and sets PC to 0x0004.
- R8: Codes 5, 6 and 7 (the three return kinds) each pop the full 13-bit PC from the most recent entry. Pushes and pops never change the holding register.
- R9: The stack is circular with 8 entries. The ninth push overwrites the entry of the first push. After nine pushes, the ninth pop returns the ninth pushed address again.
- R10: The holding register is 5 bits. It is loaded from `hi_wdata_i[4:0]` when `hi_we_i` is high, becomes visible one cycle later, and reads back on `hi_rd_o` with bits [7:5] as zero.
- R11: `pcl_o` always equals `pc_o[7:0]`.
- R12: The unused codes 9 to 15 behave as step (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code for this cycle |
| lit_i | input | 11 | Branch/call literal |
| wdata_i | input | 8 | Low-byte write value or low-byte addend |
| hi_we_i | input | 1 | Holding register write enable |
| hi_wdata_i | input | 8 | Holding register write value |
| pc_o | output | 13 | Current program counter |
| pcl_o | output | 8 | Readable low byte of the PC |
| hi_rd_o | output | 8 | Holding register read-back |

## Verification
The assertions assume that every input is a known value at each rising edge once reset is released, and that `op_i` holds one code for the whole cycle. The stack checks also assume that push and pop are never requested together. The decoder produces them from distinct codes, so this holds whenever the op code is stable. The bench drives all inputs at the falling edge from a single task, so each cycle carries exactly one defined operation. It changes reset only at falling edges, so no input changes near the sampling edge.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_STEP   = 4'd0,
        OP_SETLO  = 4'd1,
        OP_ADDLO  = 4'd2,
        OP_BRANCH = 4'd3,
        OP_CALL   = 4'd4,
        OP_RET    = 4'd5,
        OP_RETLIT = 4'd6,
        OP_RETINT = 4'd7,
        OP_IRQ    = 4'd8
    } op_e;

    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pcseq_holdreg.sv
module pcseq_holdreg #(
    parameter int HI_W = 5,
    parameter int RD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [RD_W-1:0] wdata_i,
    output logic [HI_W-1:0] hold_o,
    output logic [RD_W-1:0] rd_o
);
    localparam int PAD_W = RD_W - HI_W;

    logic [HI_W-1:0] hold_q;
    logic            unused_hi_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (we_i) begin
            hold_q <= wdata_i[HI_W-1:0];
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_o           = {{PAD_W{1'b0}}, hold_q};
            assign unused_hi_bits = ^wdata_i[RD_W-1:HI_W];
        end else begin : g_nopad
            assign rd_o           = hold_q[RD_W-1:0];
            assign unused_hi_bits = 1'b0;
        end
    endgenerate

    assign hold_o = hold_q;

    // R10: without a write the holding value does not move
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(hold_q));

    // R10: a write lands on the next edge
    p_hold_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> hold_q == $past(wdata_i[HI_W-1:0]));

endmodule

// File: rtl/pcseq_retstack.sv
module pcseq_retstack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     ent_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    // wrap explicitly so a depth that is not a power of two still cycles
    assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push_i) begin
            ptr_q <= ptr_up;
        end else if (pop_i) begin
            ptr_q <= ptr_dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ptr_q == PTR_W'(i)) begin
                    ent_q[i] <= wdata_i;
                end
            end
        end
    end

    // most recent entry sits just below the pointer
    assign top_o = ent_q[ptr_dn];

    // R6: the decoder never asks for both at once
    p_push_pop_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

    // R9: every push advances the pointer by one, wrapping silently
    p_push_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> int'(ptr_q) == (int'($past(ptr_q)) + 1) % DEPTH);

    // R8: every pop retreats the pointer by one, wrapping silently
    p_pop_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> int'(ptr_q) == (int'($past(ptr_q)) + DEPTH - 1) % DEPTH);

    // R6: a value just pushed is the one a pop would read next
    p_push_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(wdata_i));

endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LO_W    = 8,
    parameter int LIT_W   = 11,
    parameter int IRQ_VEC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [LIT_W-1:0] lit_i,
    input  logic [LO_W-1:0]  wdata_i,
    input  logic [PC_W-LO_W-1:0] hold_i,
    input  logic [PC_W-1:0]  pop_data_i,
    output logic             push_o,
    output logic             pop_o,
    output logic [PC_W-1:0]  push_data_o,
    output logic [PC_W-1:0]  pc_o
);
    localparam int HI_W  = PC_W - LO_W;
    localparam int BHI_W = PC_W - LIT_W;
    localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

    seq_state_e      st_q, st_n;
    logic [PC_W-1:0] pc_q, pc_n;
    logic [PC_W-1:0] pc_inc;
    logic [LO_W-1:0] lo_sum;
    logic [PC_W-1:0] br_tgt;

    assign pc_inc = pc_q + 1'b1;
    assign lo_sum = pc_q[LO_W-1:0] + wdata_i;
    assign br_tgt = {hold_i[HI_W-1 -: BHI_W], lit_i};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_BOOT;
            pc_q <= '0;
        end else begin
            st_q <= st_n;
            pc_q <= pc_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n        = st_q;
        pc_n        = pc_q;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_inc;
        unique case (st_q)
            ST_BOOT: begin
                st_n = ST_RUN;
            end
            ST_RUN: begin
                st_n = ST_RUN;
                case (op_i)
                    OP_SETLO:  pc_n = {hold_i, wdata_i};
                    OP_ADDLO:  pc_n = {hold_i, lo_sum};
                    OP_BRANCH: pc_n = br_tgt;
                    OP_CALL: begin
                        push_o      = 1'b1;
                        push_data_o = pc_inc;
                        pc_n        = br_tgt;
                    end
                    OP_RET, OP_RETLIT, OP_RETINT: begin
                        pop_o = 1'b1;
                        pc_n  = pop_data_i;
                    end
                    OP_IRQ: begin
                        push_o      = 1'b1;
                        push_data_o = pc_q;
                        pc_n        = VEC;
                    end
                    default:   pc_n = pc_inc;
                endcase
            end
            default: st_n = ST_BOOT;
        endcase
    end

    assign pc_o = pc_q;

    // R1: BOOT always shows address zero
    p_boot_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_BOOT |-> pc_q == '0);

    // R2: step moves the counter on by exactly one, modulo the width
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && op_i == OP_STEP) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

    // R3: set-low places the written byte in the low bits
    p_setlo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && op_i == OP_SETLO) |=> pc_q[LO_W-1:0] == $past(wdata_i));

    // R5: branch and call take the literal for the lower bits
    p_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && (op_i == OP_BRANCH || op_i == OP_CALL))
        |=> pc_q[LIT_W-1:0] == $past(lit_i));

    // R7: interrupt lands on the vector
    p_irq_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && op_i == OP_IRQ) |=> pc_q == VEC);

    // R8: any return restores what the stack held
    p_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> pc_q == $past(pop_data_i));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LO_W    = 8,
    parameter int LIT_W   = 11,
    parameter int DEPTH   = 8,
    parameter int IRQ_VEC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [LIT_W-1:0] lit_i,
    input  logic [LO_W-1:0]  wdata_i,
    input  logic             hi_we_i,
    input  logic [LO_W-1:0]  hi_wdata_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [LO_W-1:0]  pcl_o,
    output logic [LO_W-1:0]  hi_rd_o
);
    localparam int HI_W = PC_W - LO_W;

    logic [HI_W-1:0] hold;
    logic            push, pop;
    logic [PC_W-1:0] push_data, pop_data;
    logic [PC_W-1:0] pc;

    pcseq_holdreg #(
        .HI_W (HI_W),
        .RD_W (LO_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (hi_we_i),
        .wdata_i (hi_wdata_i),
        .hold_o  (hold),
        .rd_o    (hi_rd_o)
    );

    pcseq_retstack #(
        .DEPTH (DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (push_data),
        .top_o   (pop_data)
    );

    pcseq_ctrl #(
        .PC_W    (PC_W),
        .LO_W    (LO_W),
        .LIT_W   (LIT_W),
        .IRQ_VEC (IRQ_VEC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .lit_i       (lit_i),
        .wdata_i     (wdata_i),
        .hold_i      (hold),
        .pop_data_i  (pop_data),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data),
        .pc_o        (pc)
    );

    assign pc_o  = pc;
    assign pcl_o = pc[LO_W-1:0];

    // R8: stack traffic leaves the holding register alone
    p_stack_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((push || pop) && !hi_we_i) |=> $stable(hi_rd_o));

endmodule

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
    import pcseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [10:0] lit = '0;
    logic [7:0]  wd = '0;
    logic        hwe = 1'b0;
    logic [7:0]  hwd = '0;
    logic [12:0] pc_o;
    logic [7:0]  pcl_o, hi_rd_o;

    always #4 clk = ~clk;   // 125 MHz

    pc_sequencer dut_i (
        .clk (clk), .rst_n (rst_n), .op_i (op), .lit_i (lit), .wdata_i (wd),
        .hi_we_i (hwe), .hi_wdata_i (hwd),
        .pc_o (pc_o), .pcl_o (pcl_o), .hi_rd_o (hi_rd_o)
    );

    typedef struct {
        string       req;
        logic [12:0] pc;
        logic [7:0]  hi;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    // reference model state
    logic [12:0] m_pc = '0;
    logic [4:0]  m_hi = '0;
    logic [12:0] m_stk [8];
    int          m_ptr = 0;
    bit          m_boot = 1;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: compare two ns after each rising edge
    exp_t e;
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            chk(e.req, "pc", int'(pc_o), int'(e.pc));
            chk("R11", "pcl", int'(pcl_o), int'(e.pc[7:0]));
            chk(e.req, "hold", int'(hi_rd_o), int'(e.hi));
        end
    end

    task automatic drive_now(logic [3:0] o, logic [10:0] l, logic [7:0] w,
                             logic we, logic [7:0] hw, string req);
        logic [4:0] nhi;
        logic [7:0] lo;
        exp_t x;
        op = o; lit = l; wd = w; hwe = we; hwd = hw;
        nhi = we ? hw[4:0] : m_hi;
        if (m_boot) begin
            m_boot = 0;
        end else begin
            case (o)
                4'd1: m_pc = {m_hi, w};
                4'd2: begin lo = m_pc[7:0] + w; m_pc = {m_hi, lo}; end
                4'd3: m_pc = {m_hi[4:3], l};
                4'd4: begin
                    m_stk[m_ptr] = m_pc + 13'd1;
                    m_ptr = (m_ptr + 1) % 8;
                    m_pc = {m_hi[4:3], l};
                end
                4'd5, 4'd6, 4'd7: begin
                    m_ptr = (m_ptr + 7) % 8;
                    m_pc = m_stk[m_ptr];
                end
                4'd8: begin
                    m_stk[m_ptr] = m_pc;
                    m_ptr = (m_ptr + 1) % 8;
                    m_pc = 13'h0004;
                end
                default: m_pc = m_pc + 13'd1;
            endcase
        end
        m_hi = nhi;
        x.req = req; x.pc = m_pc; x.hi = {3'b000, m_hi};
        q.push_back(x);
    endtask

    task automatic step(logic [3:0] o, logic [10:0] l, logic [7:0] w,
                        logic we, logic [7:0] hw, string req);
        @(negedge clk);
        drive_now(o, l, w, we, hw, req);
    endtask

    task automatic drain();
        @(negedge clk);
        op = 4'd0; hwe = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(logic [3:0] boot_op);
        rst_n = 1'b0;
        #1;
        chk("R1", "pc in reset", int'(pc_o), 0);
        chk("R1", "hold in reset", int'(hi_rd_o), 0);
        @(negedge clk);
        m_pc = '0; m_hi = '0; m_ptr = 0; m_boot = 1;
        rst_n = 1'b1;
        drive_now(boot_op, 11'h7FF, 8'hAA, 1'b0, 8'h00, "R1");  // BOOT ignores op
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset(OP_BRANCH);
        step(OP_STEP, 0, 0, 0, 0, "R2");
        step(OP_STEP, 0, 0, 0, 0, "R2");
        step(OP_STEP, 0, 0, 1, 8'hFF, "R10");            // bits 7:5 dropped
        step(OP_SETLO, 0, 8'hFE, 1, 8'h00, "R3");         // old hold used
        step(OP_STEP, 0, 0, 0, 0, "R2");                  // 0x1FFF
        step(OP_STEP, 0, 0, 0, 0, "R2");                  // wraps to 0
        step(OP_STEP, 0, 0, 1, 8'h0A, "R10");
        step(OP_BRANCH, 11'h123, 0, 0, 0, "R5");          // 0x0923
        step(OP_ADDLO, 0, 8'hF0, 0, 0, "R4");             // 0x0A13
        step(OP_CALL, 11'h050, 0, 0, 0, "R6");            // push 0x0A14
        step(OP_IRQ, 0, 0, 0, 0, "R7");                   // push 0x0850
        step(OP_RETINT, 0, 0, 0, 0, "R8");
        step(OP_RET, 0, 0, 0, 0, "R6");
        step(4'd9, 0, 0, 0, 0, "R12");
        step(4'd15, 0, 0, 0, 0, "R12");
        step(OP_STEP, 0, 0, 1, 8'h17, "R10");
        for (int i = 0; i < 9; i++) begin
            step(OP_CALL, 11'(16 * i + 3), 0, 0, 0, "R9");
        end
        for (int i = 0; i < 9; i++) begin
            step(OP_RETLIT, 0, 0, 0, 0, "R9");
        end
        step(OP_IRQ, 0, 0, 0, 0, "R7");
        step(OP_RET, 0, 0, 0, 0, "R8");
        drain();
        do_reset(OP_IRQ);
        step(OP_CALL, 11'h321, 0, 0, 0, "R1");
        step(OP_RET, 0, 0, 0, 0, "R1");
        drain();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule